// File: doc/BRIEF.md
# Reference Clock Source Selector

This block decides which timing reference the system clocks should follow. Two external candidate references, nominally 10 MHz, arrive asynchronously: one from the timing slot and one from a rear-panel connector. The block samples each candidate in a free-running local timebase domain. It counts the candidate's rising edges over a fixed window and declares the candidate present when the count lies close to the number expected at 10 MHz.

A fixed priority turns the two presence flags into a 2-bit source-select code. The timing-slot input always wins when it is present. The rear connector is used only when the timing slot is missing. The internal oscillator is chosen when neither candidate is present. A candidate's flag changes only after two consecutive windows agree, so a brief dropout or a short burst does not move the selection. The select code is loaded only at window boundaries. The phase locking and clock multiplexing that act on the code are outside this block.

Top module: `refclk_source_sel`

## Requirements
- R1: While reset is asserted, and in the first cycles after its release, both presence flags read 0 and the select code reads 2'b00 (internal). An asynchronous assertion of reset clears them at once, even in the middle of operation.
- R2: When neither candidate is present, the select code is 2'b00 (internal oscillator).
- R3: When only the rear-connector candidate is present, the select code is 2'b01.
- R4: When only the timing-slot candidate is present, the select code is 2'b10.
- R5: When both candidates are present, the timing slot wins and the select code is 2'b10.
- R6: A window passes when its rising-edge count lies within ±TOL_PCT percent of EXP_EDGES. The defaults are 1000 timebase cycles per window and 36 to 44 edges inclusive. A candidate with a period from 92 ns to 108 ns is therefore present on a 250 MHz timebase. Periods of 50 ns, 120 ns and 200 ns, and a signal with no clock, are absent.
- R7: An absent candidate becomes present only after two consecutive passing windows. A single passing window between failing ones leaves the flag at 0.
- R8: A present candidate becomes absent only after two consecutive failing windows. A dropout that spoils only one window leaves the flag at 1.
- R9: The select code changes only in the cycle that follows a window boundary, and it never takes the value 2'b11.
- R10: At every cycle, the select code equals the priority encoding of the two presence flags given in R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| timebase_clk | input | 1 | Free-running local timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| slot_ref_i | input | 1 | Candidate reference from the timing slot, asynchronous |
| rear_ref_i | input | 1 | Candidate reference from the rear connector, asynchronous |
| src_sel_o | output | 2 | Selected source: 00 internal, 01 rear connector, 10 timing slot |
| slot_ok_o | output | 1 | Timing-slot candidate judged present |
| rear_ok_o | output | 1 | Rear-connector candidate judged present |

## Verification
Several properties are checked on every cycle: the select code moves only after a window boundary and never holds the unused value, and a flag rises or falls only at a boundary that follows a matching pending window. Other properties include that the edge counter saturates rather than wraps, and that the window tick is a single-cycle pulse. Other behaviour is visible only across many windows, so only the bench scenarios can show it. This covers the frequency acceptance band at its edges, the priority outcome for each pair of inputs, and the survival of a one-window dropout. It also covers the rejection of a burst that is too short to fill two windows.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  // Source-select encoding driven on src_sel_o
  typedef enum logic [1:0] {
    SRC_INTERNAL = 2'b00,
    SRC_REAR     = 2'b01,
    SRC_SLOT     = 2'b10
  } src_sel_e;

  // Candidate indices inside the per-reference arrays
  localparam int unsigned IDX_REAR = 0;
  localparam int unsigned IDX_SLOT = 1;
  localparam int unsigned NUM_REF  = 2;

  // Fixed priority: timing slot over rear connector over internal
  function automatic src_sel_e pick_source(input logic slot_ok, input logic rear_ok);
    src_sel_e sel;
    if (slot_ok)      sel = SRC_SLOT;
    else if (rear_ok) sel = SRC_REAR;
    else              sel = SRC_INTERNAL;
    return sel;
  endfunction

endpackage

// File: rtl/refsel_sync.sv
// Two-flop synchronizer plus rising-edge detector for one candidate.
module refsel_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic meta_q;
  logic stab_q;
  logic hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
      hist_q <= stab_q;
    end
  end

  assign rise_o = stab_q & ~hist_q;

  // A detected rise cannot repeat on the next cycle
  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R6

endmodule

// File: rtl/refsel_window.sv
// Free-running window counter; tick_o pulses in the last cycle of each window.
module refsel_window #(
  parameter int unsigned WIN_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int unsigned W_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [W_W-1:0] LAST = W_W'(WIN_CYCLES - 1);

  logic [W_W-1:0] cnt_q;
  logic [W_W-1:0] cnt_nxt;
  logic           at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    if (at_last) cnt_nxt = '0;
    else         cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign tick_o = at_last;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R9

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R9

endmodule

// File: rtl/refsel_detect.sv
// Per-candidate edge counter, frequency band check and two-window hysteresis.
module refsel_detect #(
  parameter int unsigned WIN_CYCLES = 1000,
  parameter int unsigned EXP_EDGES  = 40,
  parameter int unsigned TOL_PCT    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic tick_i,
  output logic present_o,
  output logic present_nxt_o
);

  localparam int unsigned CNT_W   = $clog2(WIN_CYCLES + 1);
  localparam int unsigned SPAN    = (EXP_EDGES * TOL_PCT) / 100;
  localparam int unsigned LO_INT  = (EXP_EDGES > SPAN) ? (EXP_EDGES - SPAN) : 0;
  localparam int unsigned HI_INT  = EXP_EDGES + SPAN;
  localparam logic [CNT_W-1:0] LO      = CNT_W'(LO_INT);
  localparam logic [CNT_W-1:0] HI      = CNT_W'(HI_INT);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] judged;
  logic             in_band;
  logic             present_q;
  logic             present_nxt;
  logic             pend_q;
  logic             pend_nxt;

  // Edge count including a rise that lands on the boundary cycle
  always_comb begin
    if (rise_i && (cnt_q != CNT_MAX)) judged = cnt_q + 1'b1;
    else                              judged = cnt_q;
    in_band = (judged >= LO) && (judged <= HI);
  end

  // Counter next state
  always_comb begin
    if (tick_i) cnt_nxt = '0;
    else        cnt_nxt = judged;
  end

  // Hysteresis next state: a disagreeing window arms pend, a second flips the flag
  always_comb begin
    present_nxt = present_q;
    pend_nxt    = pend_q;
    if (tick_i) begin
      if (in_band == present_q) begin
        pend_nxt = 1'b0;
      end else if (pend_q) begin
        present_nxt = in_band;
        pend_nxt    = 1'b0;
      end else begin
        pend_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      present_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      cnt_q     <= cnt_nxt;
      present_q <= present_nxt;
      pend_q    <= pend_nxt;
    end
  end

  assign present_o     = present_q;
  assign present_nxt_o = present_nxt;

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !tick_i) |=> (cnt_q == CNT_MAX)); // R6

  AST_RISE_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(present_q) |-> ($past(tick_i) && $past(pend_q))); // R7

  AST_FALL_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(present_q) |-> ($past(tick_i) && $past(pend_q))); // R8

endmodule

// File: rtl/refclk_source_sel.sv
module refclk_source_sel
  import refsel_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 1000,
  parameter int unsigned EXP_EDGES  = 40,
  parameter int unsigned TOL_PCT    = 10
) (
  input  logic       timebase_clk,
  input  logic       rst_n,
  input  logic       slot_ref_i,
  input  logic       rear_ref_i,
  output logic [1:0] src_sel_o,
  output logic       slot_ok_o,
  output logic       rear_ok_o
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge timebase_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                win_tick;
  logic [NUM_REF-1:0]  ref_raw;
  logic [NUM_REF-1:0]  ref_rise;
  logic [NUM_REF-1:0]  ok_q;
  logic [NUM_REF-1:0]  ok_nxt;

  assign ref_raw[IDX_REAR] = rear_ref_i;
  assign ref_raw[IDX_SLOT] = slot_ref_i;

  refsel_window #(.WIN_CYCLES(WIN_CYCLES)) i_window (
    .clk    (timebase_clk),
    .rst_n  (rst_sync_n),
    .tick_o (win_tick)
  );

  for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
    refsel_sync i_sync (
      .clk     (timebase_clk),
      .rst_n   (rst_sync_n),
      .async_i (ref_raw[g]),
      .rise_o  (ref_rise[g])
    );

    refsel_detect #(
      .WIN_CYCLES (WIN_CYCLES),
      .EXP_EDGES  (EXP_EDGES),
      .TOL_PCT    (TOL_PCT)
    ) i_detect (
      .clk           (timebase_clk),
      .rst_n         (rst_sync_n),
      .rise_i        (ref_rise[g]),
      .tick_i        (win_tick),
      .present_o     (ok_q[g]),
      .present_nxt_o (ok_nxt[g])
    );
  end

  // Select register: loaded only on the window boundary
  src_sel_e sel_q;
  src_sel_e sel_nxt;
  logic     sel_en;

  always_comb begin
    sel_en  = win_tick;
    sel_nxt = pick_source(ok_nxt[IDX_SLOT], ok_nxt[IDX_REAR]);
  end

  always_ff @(posedge timebase_clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  sel_q <= SRC_INTERNAL;
    else if (sel_en)  sel_q <= sel_nxt;
  end

  assign src_sel_o = sel_q;
  assign slot_ok_o = ok_q[IDX_SLOT];
  assign rear_ok_o = ok_q[IDX_REAR];

  AST_SEL_AT_BOUNDARY: assert property (@(posedge timebase_clk) disable iff (!rst_sync_n)
    !$past(win_tick) |-> $stable(src_sel_o)); // R9

  AST_SEL_LEGAL: assert property (@(posedge timebase_clk) disable iff (!rst_sync_n)
    src_sel_o != 2'b11); // R9

  AST_SLOT_WINS: assert property (@(posedge timebase_clk) disable iff (!rst_sync_n)
    slot_ok_o |-> (src_sel_o == 2'b10)); // R5

  AST_REAR_ONLY: assert property (@(posedge timebase_clk) disable iff (!rst_sync_n)
    (!slot_ok_o && rear_ok_o) |-> (src_sel_o == 2'b01)); // R3

  AST_NONE_INTERNAL: assert property (@(posedge timebase_clk) disable iff (!rst_sync_n)
    (!slot_ok_o && !rear_ok_o) |-> (src_sel_o == 2'b00)); // R2

  AST_RESET_STATE: assert property (@(posedge timebase_clk)
    !rst_sync_n |-> (src_sel_o == 2'b00 && !slot_ok_o && !rear_ok_o)); // R1

endmodule

// File: tb/test_refclk_source_sel.sv
`timescale 1ns/1ps
module test_refclk_source_sel;

  localparam int WIN     = 1000;
  localparam int WAIT_W  = 4 * WIN;
  localparam int WD_CYC  = 150000;

  logic       clk;
  logic       rst_n;
  logic       slot_clk;
  logic       rear_clk;
  logic [1:0] sel;
  logic       slot_ok;
  logic       rear_ok;

  int slot_per;
  int rear_per;
  int n_checks;
  int n_errors;
  bit done;

  refclk_source_sel i_refclk_source_sel (
    .timebase_clk (clk),
    .rst_n        (rst_n),
    .slot_ref_i   (slot_clk),
    .rear_ref_i   (rear_clk),
    .src_sel_o    (sel),
    .slot_ok_o    (slot_ok),
    .rear_ok_o    (rear_ok)
  );

  // 250 MHz timebase
  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // Candidate generators; period 0 holds the line low
  initial begin
    slot_clk = 1'b0;
    forever begin
      if (slot_per == 0) begin slot_clk = 1'b0; #3; end
      else begin #(slot_per / 2.0); slot_clk = ~slot_clk; end
    end
  end

  initial begin
    rear_clk = 1'b0;
    forever begin
      if (rear_per == 0) begin rear_clk = 1'b0; #3; end
      else begin #(rear_per / 2.0); rear_clk = ~rear_clk; end
    end
  end

  // Columns: slot period ns, rear period ns, exp slot_ok, exp rear_ok, exp sel, requirement
  localparam int NV = 10;
  localparam int VEC [NV][6] = '{
    '{  0,   0, 0, 0, 0, 2},   // R2 nothing present
    '{  0, 100, 0, 1, 1, 3},   // R3 rear only
    '{100, 100, 1, 1, 2, 5},   // R5 both
    '{100,   0, 1, 0, 2, 4},   // R4 slot only
    '{ 92,   0, 1, 0, 2, 6},   // R6 fast edge of band
    '{108, 108, 1, 1, 2, 6},   // R6 slow edge of band
    '{120, 100, 0, 1, 1, 6},   // R6 slot too slow
    '{200,  50, 0, 0, 0, 6},   // R6 both out of band
    '{100, 200, 1, 0, 2, 4},   // R4 rear out of band
    '{  0,   0, 0, 0, 0, 2}    // R2 back to internal
  };

  function automatic string req_name(input int r);
    case (r)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic int exp_sel(input logic s, input logic r);
    if (s) return 2;
    if (r) return 1;
    return 0;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit hold_bad;
    n_checks = 0;
    n_errors = 0;
    done     = 1'b0;
    slot_per = 0;
    rear_per = 0;
    rst_n    = 1'b0;
    wait_cyc(5);
    check("R1", "slot_ok in reset", slot_ok, 0);
    check("R1", "rear_ok in reset", rear_ok, 0);
    check("R1", "sel in reset", sel, 0);
    rst_n = 1'b1;
    wait_cyc(3);
    check("R1", "sel after release", sel, 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      slot_per = VEC[v][0];
      rear_per = VEC[v][1];
      wait_cyc(WAIT_W);
      check(req_name(VEC[v][5]), "slot_ok", slot_ok, VEC[v][2]);
      check(req_name(VEC[v][5]), "rear_ok", rear_ok, VEC[v][3]);
      check(req_name(VEC[v][5]), "sel", sel, VEC[v][4]);
      check("R10", "sel vs flags", sel, exp_sel(slot_ok, rear_ok));
    end

    // R8: a 600 ns dropout spoils at most one window
    slot_per = 100;
    rear_per = 100;
    wait_cyc(WAIT_W);
    check("R8", "slot_ok before dropout", slot_ok, 1);
    slot_per = 0;
    #600;
    slot_per = 100;
    hold_bad = 1'b0;
    for (int i = 0; i < 3 * WIN; i++) begin
      @(negedge clk);
      if (slot_ok !== 1'b1 || sel !== 2'b10) hold_bad = 1'b1;
    end
    check("R8", "slot held through dropout", hold_bad, 0);

    // R7: a 5200 ns burst holds at most one passing window
    slot_per = 0;
    rear_per = 0;
    wait_cyc(WAIT_W);
    check("R7", "slot_ok before burst", slot_ok, 0);
    slot_per = 100;
    #5200;
    slot_per = 0;
    hold_bad = 1'b0;
    for (int i = 0; i < WAIT_W; i++) begin
      @(negedge clk);
      if (slot_ok !== 1'b0 || sel !== 2'b00) hold_bad = 1'b1;
    end
    check("R7", "burst rejected", hold_bad, 0);

    // R9: code stays legal and follows the flags over a long run
    rear_per = 100;
    hold_bad = 1'b0;
    for (int i = 0; i < WAIT_W; i++) begin
      @(negedge clk);
      if (sel == 2'b11 || int'(sel) != exp_sel(slot_ok, rear_ok)) hold_bad = 1'b1;
    end
    check("R9", "sel legal and consistent", hold_bad, 0);
    check("R3", "rear picked after settle", sel, 1);

    // R1: asynchronous reset in mid-operation
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1", "rear_ok cleared at once", rear_ok, 0);
    check("R1", "sel cleared at once", sel, 0);
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(WAIT_W);
    check("R3", "rear recovered after reset", sel, 1);

    finish_run();
  end

endmodule